// File: doc/BRIEF.md
# Write-Once Halfword OTP Filter

This block keeps a small array of 32-bit registers and makes it behave like one-time-programmable memory. Every register starts in the erased state (all ones) at reset. A write request is judged as a whole: it must be a secure, full-word transfer. Each 16-bit half of the write data must either be the mask value 0xFFFF or target a half that is still erased. Only a request that passes every rule changes storage. A request that fails any rule is dropped in full and raises a sticky violation flag.

Firmware can program both halves of a location in one write, or program them one at a time with the untouched half masked as 0xFFFF. An accepted write stores the AND of the old and new words, so a bit can only fall from 1 to 0. Reads are a plain combinational look-up of the addressed word and never alter storage. The violation flag stays set until the status-clear input is pulsed.

Top module: `otp_half_guard`

## Requirements
- R1: After reset every word reads 0xFFFFFFFF and `blocked` is 0.
- R2: A write with `wrSecure` low leaves storage unchanged, and `blocked` is 1 from the next clock edge.
- R3: Transfer size is encoded on `wrSize` as 0 = byte, 1 = halfword, 2 = word, 3 = reserved. Any write whose size is not 2 leaves storage unchanged and sets `blocked`.
- R4: If a half of the write data (bits 31:16 or 15:0) differs from 0xFFFF while the stored half is not 0xFFFF, the whole write is dropped. The other half is not changed either, and `blocked` is set.
- R5: A write half equal to 0xFFFF over a programmed half is accepted as a no-op for that half and does not set `blocked`.
- R6: An accepted write stores (old AND new) at `wrAddr` in the clock edge where `wrEn` is high. For example, 0xFFFFAABB written with 0x1234FFFF becomes 0x1234AABB.
- R7: `blocked` stays 1 until a cycle with `statusClr` high. If a failing write happens in the same cycle as the clear, `blocked` stays 1.
- R8: `rdData` shows the word at `rdAddr` combinationally. A write changes no other address.
- R9: With `wrEn` low, storage and `blocked` do not change, whatever the other write inputs carry (apart from `statusClr`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write request for this cycle |
| wrSecure | input | 1 | Request comes from the secure world |
| wrSize | input | 2 | Transfer size code (0 byte, 1 half, 2 word, 3 reserved) |
| wrAddr | input | ADDR_W | Word index of the write |
| wrData | input | 32 | Write data |
| statusClr | input | 1 | Pulse to clear the violation flag |
| rdAddr | input | ADDR_W | Word index of the read |
| rdData | output | 32 | Word stored at rdAddr |
| blocked | output | 1 | Sticky flag: a write was refused |

## Verification
The bound checker watches every cycle for these properties: non-secure and non-word writes always raise the flag, the flag holds without a clear, an idle cycle issues no strobes, and no commit ever reprograms a programmed half. Whether a stored word ends up as the exact AND of old and new, whether neighbouring words stay untouched, and how a clear that coincides with a violation resolves are shown only by the bench. Its sweep over addresses, security, sizes and half patterns compares against a reference model of the array.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int HALVES = WORD_W / HALF_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xferSize_e;

  typedef struct packed {
    logic commit;
    logic flagBlock;
    logic flagClear;
  } otpStrobe_t;
endpackage

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
(
  input  logic              wrEn,
  input  logic              wrSecure,
  input  logic [1:0]        wrSize,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] oldWord,
  input  logic              statusClr,
  output otpStrobe_t        strb
);
  localparam logic [HALF_W-1:0] ERASED = '1;

  logic [HALVES-1:0] halfOk;
  logic              xferOk;
  logic              allOk;

  // each half: mask value, or target still erased
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [HALF_W-1:0] newHalf;
    logic [HALF_W-1:0] curHalf;
    assign newHalf   = wrData[h*HALF_W +: HALF_W];
    assign curHalf   = oldWord[h*HALF_W +: HALF_W];
    assign halfOk[h] = (newHalf == ERASED) || (curHalf == ERASED);
  end

  assign xferOk = wrSecure && (xferSize_e'(wrSize) == SZ_WORD);
  assign allOk  = xferOk && (&halfOk);

  always_comb begin
    strb.commit    = wrEn && allOk;
    strb.flagBlock = wrEn && !allOk;
    strb.flagClear = statusClr;
  end
endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  otpStrobe_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] oldWord,
  output logic [WORD_W-1:0] rdData,
  output logic              blocked
);
  logic [WORD_W-1:0] mem [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        mem[w] <= '1;
      else if (strb.commit && (wrAddr == ADDR_W'(w)))
        mem[w] <= mem[w] & wrData;
    end
  end

  assign oldWord = mem[wrAddr];
  assign rdData  = mem[rdAddr];

  // violation flag: set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      blocked <= 1'b0;
    else if (strb.flagBlock)
      blocked <= 1'b1;
    else if (strb.flagClear)
      blocked <= 1'b0;
  end
endmodule

// File: rtl/otp_half_guard.sv
module otp_half_guard
  import otp_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSecure,
  input  logic [1:0]        wrSize,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              statusClr,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              blocked
);
  otpStrobe_t        strb;
  logic [WORD_W-1:0] oldWord;

  otp_ctrl u_ctrl (
    .wrEn      (wrEn),
    .wrSecure  (wrSecure),
    .wrSize    (wrSize),
    .wrData    (wrData),
    .oldWord   (oldWord),
    .statusClr (statusClr),
    .strb      (strb)
  );

  otp_store #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .oldWord (oldWord),
    .rdData  (rdData),
    .blocked (blocked)
  );
endmodule

// File: rtl/otp_half_guard_chk.sv
module otp_half_guard_chk
  import otp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              wrSecure,
  input logic [1:0]        wrSize,
  input logic [WORD_W-1:0] wrData,
  input logic              statusClr,
  input logic [WORD_W-1:0] oldWord,
  input otpStrobe_t        strb,
  input logic              blocked
);
  // R2
  nonsecure_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !wrSecure |=> blocked);

  // R3
  size_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (wrSize != 2'd2) |=> blocked);

  // R4
  no_reprogram_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |->
      ((wrData[31:16] == 16'hFFFF) || (oldWord[31:16] == 16'hFFFF)) &&
      ((wrData[15:0]  == 16'hFFFF) || (oldWord[15:0]  == 16'hFFFF)));

  // R7
  blocked_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    blocked && !statusClr |=> blocked);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !strb.commit && !strb.flagBlock);

  // R9
  idle_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn && !statusClr |=> $stable(blocked));
endmodule

bind otp_half_guard otp_half_guard_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrSecure  (wrSecure),
  .wrSize    (wrSize),
  .wrData    (wrData),
  .statusClr (statusClr),
  .oldWord   (oldWord),
  .strb      (strb),
  .blocked   (blocked)
);

// File: tb/otp_half_guard_tb.sv
module otp_half_guard_tb;
  localparam int WORDS  = 4;
  localparam int ADDR_W = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic              wrSecure = 1'b0;
  logic [1:0]        wrSize = 2'd0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [31:0]       wrData = '0;
  logic              statusClr = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [31:0]       rdData;
  logic              blocked;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [WORDS];
  logic        expBlk;

  always #4 clk = ~clk;

  otp_half_guard #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSecure(wrSecure), .wrSize(wrSize),
    .wrAddr(wrAddr), .wrData(wrData), .statusClr(statusClr), .rdAddr(rdAddr),
    .rdData(rdData), .blocked(blocked)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int a = 0; a < WORDS; a++) begin
      rdAddr = ADDR_W'(a);
      #1;
      check(tag, rdData, model[a]);
    end
    check(tag, {31'd0, blocked}, {31'd0, expBlk});
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int a = 0; a < WORDS; a++) model[a] = '1;
    expBlk = 1'b0;
  endtask

  function automatic logic halfOk(input logic [15:0] nw, input logic [15:0] od);
    return (nw == 16'hFFFF) || (od == 16'hFFFF);
  endfunction

  // one cycle on the write port; model updated from the requirements
  task automatic doWrite(input int addr, input logic [31:0] d, input logic sec,
                         input logic [1:0] sz, input logic clr);
    logic ok;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ADDR_W'(addr); wrData = d;
    wrSecure = sec; wrSize = sz; statusClr = clr;
    ok = sec && (sz == 2'd2) && halfOk(d[31:16], model[addr][31:16]) &&
         halfOk(d[15:0], model[addr][15:0]);
    if (ok) model[addr] = model[addr] & d;
    if (!ok) expBlk = 1'b1;
    else if (clr) expBlk = 1'b0;
    @(negedge clk);
    wrEn = 1'b0; statusClr = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk);
    statusClr = 1'b1;
    @(negedge clk);
    statusClr = 1'b0;
    expBlk = 1'b0;
  endtask

  function automatic logic [15:0] pickHalf(input int k);
    if (k % 3 == 0) return 16'hFFFF;
    return 16'h1111 * 16'(k % 7) ^ 16'h0F0F;
  endfunction

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    doReset();
    checkAll("R1 reset state");

    // sweep: address x security x size x half patterns (R2 R3 R4 R5 R6 R8)
    for (int a = 0; a < WORDS; a++)
      for (int s = 0; s < 2; s++)
        for (int z = 0; z < 4; z++)
          for (int p = 0; p < 6; p++) begin
            pulseClear();
            check("R7 clear", {31'd0, blocked}, 32'd0);
            doWrite(a, {pickHalf(p + z), pickHalf(p + a + 1)}, s[0], z[1:0], 1'b0);
            checkAll("R2 R3 R4 R5 R6 R8 sweep");
          end

    // worked example and one-half-at-a-time programming
    doReset();
    checkAll("R1 second reset");
    doWrite(1, 32'hFFFFAABB, 1'b1, 2'd2, 1'b0);
    checkAll("R6 low half");
    doWrite(1, 32'h1234FFFF, 1'b1, 2'd2, 1'b0);
    rdAddr = 2'd1; #1;
    check("R6 example result", rdData, 32'h1234AABB);
    check("R5 mask no block", {31'd0, blocked}, 32'd0);
    doWrite(1, 32'hFFFFFFFF, 1'b1, 2'd2, 1'b0);
    checkAll("R5 all-mask write");
    doWrite(1, 32'h0000FFFF, 1'b1, 2'd2, 1'b0);
    checkAll("R4 reprogram high refused");
    check("R4 blocked", {31'd0, blocked}, 32'd1);

    // sticky and idle behaviour
    @(negedge clk);
    wrData = 32'h0; wrSecure = 1'b1; wrSize = 2'd2; wrAddr = 2'd2;
    repeat (5) @(negedge clk);
    checkAll("R7 R9 sticky and idle");

    // clear in same cycle as a failing write: set wins
    doWrite(0, 32'h00000000, 1'b0, 2'd2, 1'b1);
    checkAll("R7 set beats clear");
    check("R7 still set", {31'd0, blocked}, 32'd1);
    // clear with an accepted write
    doWrite(3, 32'hFF00FF00, 1'b1, 2'd2, 1'b1);
    checkAll("R7 R6 clear with good write");
    // halfword-size write with erased target still refused
    doWrite(2, 32'h12345678, 1'b1, 2'd1, 1'b0);
    checkAll("R3 halfword size");
    doWrite(2, 32'h12345678, 1'b1, 2'd3, 1'b0);
    checkAll("R3 reserved size");
    pulseClear();
    doWrite(2, 32'h12345678, 1'b0, 2'd2, 1'b0);
    checkAll("R2 nonsecure");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule